// File: doc/BRIEF.md
# Sequential 32x32 Signed Multiplier Built from 16-bit Partial Products

This block forms the full 64-bit signed product of two 32-bit operands using nothing wider than one 16x16 multiplier (with per-operand signed or unsigned treatment) and a 36-bit accumulator. Each operand arrives as an upper and a lower 16-bit word. The lower-by-lower partial product is formed by clearing the top bit of the first lower word, multiplying it as signed against the second lower word as unsigned, and then adding a correction term when the cleared bit was set. That gives a true unsigned-by-unsigned partial product. Between stages the accumulator is shifted arithmetically right by 16 bits, and the word that falls out of the bottom becomes part of the result.

Every partial product uses fractional alignment: the multiplier output is doubled. In fractional mode the 64-bit result is therefore twice the integer product, taken modulo 2^64. In integer mode the assembled 68-bit value is shifted arithmetically right by one more bit, which gives the exact integer product. The result leaves the block as four 16-bit words, lowest first, on consecutive cycles under a word-valid strobe. A one-cycle done pulse marks the last word.

Top module: `split_mul32`

## Requirements
- R1: A start pulse sampled while the block is idle is accepted: busy is high in the cycle after that clock edge, and the operands and mode are captured at that edge.
- R2: A start pulse sampled while busy is high has no effect. Operand or mode changes made during an operation also have no effect; the result words belong to the accepted operands.
- R3: With the mode input low (fractional), the four words form the 64-bit value (2*a*b) mod 2^64, where a = {a_hi,a_lo} and b = {b_hi,b_lo} are signed 32-bit values.
- R4: With the mode input high (integer), the four words form the exact 64-bit signed product a*b.
- R5: The result appears as four words on four consecutive cycles, word 0 (bits 15:0) first, with word_valid high on each. The first word is valid after the seventh clock edge following the accepting edge.
- R6: done is high for exactly one cycle, in the same cycle as the fourth result word.
- R7: busy stays high from acceptance up to the edge that presents the last word, and it is low in the cycle in which done is high.
- R8: Lower operand words whose bit 15 is set give correct products. The low-by-low partial product is corrected to unsigned-by-unsigned.
- R9: Most-negative operands (0x80000000 on either side or on both sides) give correct products in both modes.
- R10: During reset and in the cycle after it, busy, word_valid and done are low.
- R11: A start sampled in the cycle in which done is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a multiplication |
| a_hi_i | input | 16 | Upper word of operand a (signed) |
| a_lo_i | input | 16 | Lower word of operand a |
| b_hi_i | input | 16 | Upper word of operand b (signed) |
| b_lo_i | input | 16 | Lower word of operand b |
| int_mode_i | input | 1 | 1 = integer result, 0 = fractional result |
| busy_o | output | 1 | Operation in progress |
| word_o | output | 16 | Current result word |
| word_valid_o | output | 1 | word_o carries a result word |
| done_o | output | 1 | Last result word is on word_o |

## Verification
The checker watches the handshake in every cycle: busy rising only after a start, done lasting one cycle and coinciding with word_valid after exactly three earlier valid words, busy low while done is high, word_valid staying up until done, and quiet outputs after reset. Arithmetic correctness cannot be expressed as a simple property. This covers the correction add, the cross products, the 16-bit shifts and the integer-mode shift. The same holds for ignoring a start or operand change mid-run. Only the bench can show these: its reference model compares each output word against a behavioural 64-bit product over mixed patterns, lower words with bit 15 set, most-negative operands and back-to-back starts.

// File: rtl/split_mul32_pkg.sv
package split_mul32_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LL, ST_FIX, ST_HL, ST_LH, ST_HH, ST_FIN, ST_EMIT
  } seq_state_t;

  typedef enum logic [2:0] {
    ACC_HOLD, ACC_LOAD, ACC_ADD, ACC_FIX, ACC_SHADD
  } acc_op_t;

  typedef enum logic [1:0] {
    SEL_LL, SEL_HL, SEL_LH, SEL_HH
  } mul_sel_t;
endpackage

// File: rtl/split_mul32_pmul.sv
// One 16x16 partial multiplier. Each operand is treated as signed or
// unsigned; the product is doubled (fractional alignment) and sign-extended.
module split_mul32_pmul #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 36
) (
  input  logic [WORD_W-1:0]       x_i,
  input  logic                    x_signed_i,
  input  logic [WORD_W-1:0]       y_i,
  input  logic                    y_signed_i,
  output logic signed [ACC_W-1:0] prod_o
);
  localparam int EXT_W  = WORD_W + 1;
  localparam int RAW_W  = 2 * EXT_W;
  localparam int PAD_W  = ACC_W - RAW_W;

  logic signed [EXT_W-1:0] xe, ye;
  logic signed [RAW_W-1:0] raw;
  logic signed [ACC_W-1:0] wide;

  always_comb begin
    xe     = {x_signed_i & x_i[WORD_W-1], x_i};
    ye     = {y_signed_i & y_i[WORD_W-1], y_i};
    raw    = xe * ye;
    wide   = {{PAD_W{raw[RAW_W-1]}}, raw};
    prod_o = {wide[ACC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/split_mul32_acc.sv
// Accumulator with load, add, correction add and shift-then-add.
module split_mul32_acc
  import split_mul32_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 36
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  acc_op_t                 op_i,
  input  logic signed [ACC_W-1:0] prod_i,
  input  logic [WORD_W-1:0]       corr_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int HI_PAD = ACC_W - 2 * WORD_W;

  logic signed [ACC_W-1:0] corr_term;
  assign corr_term = {{HI_PAD{1'b0}}, corr_i, {WORD_W{1'b0}}};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_o <= '0;
    end else begin
      case (op_i)
        ACC_LOAD:  acc_o <= prod_i;
        ACC_ADD:   acc_o <= acc_o + prod_i;
        ACC_FIX:   acc_o <= acc_o + corr_term;
        ACC_SHADD: acc_o <= (acc_o >>> WORD_W) + prod_i;
        default:   acc_o <= acc_o;
      endcase
    end
  end
endmodule

// File: rtl/split_mul32_ctrl.sv
// Sequencer: stage order, accumulator commands and output word index.
module split_mul32_ctrl
  import split_mul32_pkg::*;
#(
  parameter int RES_WORDS = 4,
  localparam int IDX_W    = $clog2(RES_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             fix_needed_i,
  output seq_state_t       state_o,
  output acc_op_t          acc_op_o,
  output mul_sel_t         sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RES_WORDS - 1);

  seq_state_t nxt;

  assign accept_o = (state_o == ST_IDLE) && start_i;

  always_comb begin
    nxt = state_o;
    case (state_o)
      ST_IDLE: if (start_i) nxt = ST_LL;
      ST_LL:   nxt = ST_FIX;
      ST_FIX:  nxt = ST_HL;
      ST_HL:   nxt = ST_LH;
      ST_LH:   nxt = ST_HH;
      ST_HH:   nxt = ST_FIN;
      ST_FIN:  nxt = ST_EMIT;
      ST_EMIT: if (idx_o == LAST_IDX) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    acc_op_o = ACC_HOLD;
    sel_o    = SEL_LL;
    case (state_o)
      ST_LL:  begin acc_op_o = ACC_LOAD;  sel_o = SEL_LL; end
      ST_FIX: acc_op_o = fix_needed_i ? ACC_FIX : ACC_HOLD;
      ST_HL:  begin acc_op_o = ACC_SHADD; sel_o = SEL_HL; end
      ST_LH:  begin acc_op_o = ACC_ADD;   sel_o = SEL_LH; end
      ST_HH:  begin acc_op_o = ACC_SHADD; sel_o = SEL_HH; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_o <= ST_IDLE;
      idx_o   <= '0;
    end else begin
      state_o <= nxt;
      if (state_o == ST_EMIT) idx_o <= idx_o + 1'b1;
      else                    idx_o <= '0;
    end
  end
endmodule

// File: rtl/split_mul32.sv
module split_mul32
  import split_mul32_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] a_hi_i,
  input  logic [WORD_W-1:0] a_lo_i,
  input  logic [WORD_W-1:0] b_hi_i,
  input  logic [WORD_W-1:0] b_lo_i,
  input  logic              int_mode_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              done_o
);
  localparam int ACC_W     = 2 * WORD_W + GUARD_W;
  localparam int RES_WORDS = 4;
  localparam int RES_W     = RES_WORDS * WORD_W;
  localparam int FULL_W    = ACC_W + 2 * WORD_W;
  localparam int IDX_W     = $clog2(RES_WORDS);

  seq_state_t              state;
  acc_op_t                 acc_op;
  mul_sel_t                sel;
  logic [IDX_W-1:0]        idx;
  logic                    accept;

  logic [WORD_W-1:0]       a_hi_q, a_lo_q, b_hi_q, b_lo_q;
  logic                    int_q;
  logic [WORD_W-1:0]       mx, my;
  logic                    mx_s, my_s;
  logic signed [ACC_W-1:0] prod, acc;
  logic [WORD_W-1:0]       w0_q, w1_q;
  logic signed [FULL_W-1:0] full;
  logic [RES_W-1:0]        res_q;
  logic [WORD_W-1:0]       res_words [RES_WORDS];

  split_mul32_ctrl #(.RES_WORDS(RES_WORDS)) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
    .fix_needed_i(a_lo_q[WORD_W-1]),
    .state_o(state), .acc_op_o(acc_op), .sel_o(sel),
    .idx_o(idx), .accept_o(accept)
  );

  // Operand capture on acceptance only
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      a_hi_q <= '0; a_lo_q <= '0; b_hi_q <= '0; b_lo_q <= '0; int_q <= 1'b0;
    end else if (accept) begin
      a_hi_q <= a_hi_i; a_lo_q <= a_lo_i;
      b_hi_q <= b_hi_i; b_lo_q <= b_lo_i;
      int_q  <= int_mode_i;
    end
  end

  // Partial-product operand routing
  always_comb begin
    case (sel)
      SEL_HL:  begin mx = a_hi_q; mx_s = 1'b1; my = b_lo_q; my_s = 1'b0; end
      SEL_LH:  begin mx = b_hi_q; mx_s = 1'b1; my = a_lo_q; my_s = 1'b0; end
      SEL_HH:  begin mx = a_hi_q; mx_s = 1'b1; my = b_hi_q; my_s = 1'b1; end
      default: begin
        mx = {1'b0, a_lo_q[WORD_W-2:0]}; mx_s = 1'b1;
        my = b_lo_q;                     my_s = 1'b0;
      end
    endcase
  end

  split_mul32_pmul #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_pmul (
    .x_i(mx), .x_signed_i(mx_s), .y_i(my), .y_signed_i(my_s), .prod_o(prod)
  );

  split_mul32_acc #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_i(rst_i), .op_i(acc_op),
    .prod_i(prod), .corr_i(b_lo_q), .acc_o(acc)
  );

  assign full = {acc, w1_q, w0_q};

  // Low words shed by the accumulator, then final assembly
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      w0_q  <= '0;
      w1_q  <= '0;
      res_q <= '0;
    end else begin
      if (state == ST_HL) w0_q <= acc[WORD_W-1:0];
      if (state == ST_HH) w1_q <= acc[WORD_W-1:0];
      if (state == ST_FIN) res_q <= int_q ? RES_W'(full >>> 1) : RES_W'(full);
    end
  end

  for (genvar g = 0; g < RES_WORDS; g++) begin : g_slice
    assign res_words[g] = res_q[g*WORD_W +: WORD_W];
  end

  // Registered output stage
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
      done_o       <= 1'b0;
    end else if (state == ST_EMIT) begin
      word_o       <= res_words[idx];
      word_valid_o <= 1'b1;
      done_o       <= (idx == IDX_W'(RES_WORDS - 1));
    end else begin
      word_valid_o <= 1'b0;
      done_o       <= 1'b0;
    end
  end

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/split_mul32_chk.sv
module split_mul32_chk (
  input logic clk_i,
  input logic rst_i,
  input logic start_i,
  input logic busy_o,
  input logic word_valid_o,
  input logic done_o
);
  logic [2:0] run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)             run_q <= '0;
    else if (word_valid_o) run_q <= run_q + 1'b1;
    else                   run_q <= '0;
  end

  assert_busy_after_start_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> $past(start_i));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  assert_done_with_word_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (word_valid_o && run_q == 3'd3));

  assert_words_contiguous_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (word_valid_o && !done_o) |=> word_valid_o);

  assert_busy_low_at_done_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o);

  assert_busy_ends_at_done_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> done_o);

  assert_quiet_after_reset_R10: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!busy_o && !word_valid_o && !done_o));
endmodule

bind split_mul32 split_mul32_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
  .busy_o(busy_o), .word_valid_o(word_valid_o), .done_o(done_o)
);

// File: tb/split_mul32_bench.sv
module split_mul32_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic        imode = 1'b0;
  logic        busy, wvalid, done;
  logic [15:0] word;

  int nchecks = 0;
  int nerr    = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  split_mul32 u_split_mul32 (
    .clk_i(clk), .rst_i(rst), .start_i(start),
    .a_hi_i(a_hi), .a_lo_i(a_lo), .b_hi_i(b_hi), .b_lo_i(b_lo),
    .int_mode_i(imode), .busy_o(busy), .word_o(word),
    .word_valid_o(wvalid), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_result(input logic [31:0] a,
                                             input logic [31:0] b,
                                             input logic im);
    longint av, bv, p;
    av = longint'($signed(a));
    bv = longint'($signed(b));
    p  = av * bv;
    return im ? 64'(p) : 64'(p) << 1;
  endfunction

  // Behavioural reference: phase counts clock edges since acceptance
  int          phase = 0;
  logic [63:0] exp_res = '0;
  string       cur_tag = "";
  string       run_tag = "";

  always @(posedge clk) begin
    if (rst) begin
      phase <= 0;
    end else if ((phase == 0 || phase == 11) && start) begin
      phase   <= 1;
      exp_res <= ref_result({a_hi, a_lo}, {b_hi, b_lo}, imode);
      run_tag <= imode ? {"R4 ", cur_tag} : {"R3 ", cur_tag};
    end else if (phase == 11) begin
      phase <= 0;
    end else if (phase != 0) begin
      phase <= phase + 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      chk(!busy && !wvalid && !done, "R10 reset outputs",
          {61'd0, busy, wvalid, done}, 64'd0);
    end else begin
      bit eb, ev, ed;
      eb = (phase >= 1 && phase <= 10);
      ev = (phase >= 8 && phase <= 11);
      ed = (phase == 11);
      chk(busy == eb, "R1 R7 busy", 64'(busy), 64'(eb));
      chk(wvalid == ev, "R5 word_valid", 64'(wvalid), 64'(ev));
      chk(done == ed, "R6 done", 64'(done), 64'(ed));
      if (ev && wvalid)
        chk(word == exp_res[(phase-8)*16 +: 16], {run_tag, " word"},
            64'(word), 64'(exp_res[(phase-8)*16 +: 16]));
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic im, input string tag);
    @(negedge clk);
    cur_tag = tag;
    {a_hi, a_lo} = a; {b_hi, b_lo} = b; imode = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    nerr++; nchecks++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: first cycle after reset checked by the compare loop
    run_op(32'h0000_0003, 32'h0000_0005, 1'b1, "small");
    run_op(32'h0000_0003, 32'h0000_0005, 1'b0, "small");
    run_op(32'hFFFF_FFFF, 32'h0000_0007, 1'b1, "neg one");
    // R8: lower words with bit 15 set
    run_op(32'h1234_8001, 32'h0001_FFFF, 1'b1, "R8 lo msb");
    run_op(32'h0000_FFFF, 32'h0000_FFFF, 1'b0, "R8 lo msb");
    run_op(32'hABCD_9876, 32'h7654_C321, 1'b1, "R8 lo msb");
    // R9: most-negative operands
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R9 minneg");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, "R9 minneg");
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R9 minneg");
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R9 minneg");
    for (int k = 0; k < 12; k++) begin
      logic [31:0] av, bv;
      av = 32'h9E37_79B9 * 32'(k + 1) + 32'h1357_9BDF;
      bv = 32'h85EB_CA6B * 32'(k + 3) ^ 32'h2468_ACE0;
      run_op(av, bv, k[0], "mixed");
    end
    // R2: start and operand change while busy are ignored
    @(negedge clk);
    cur_tag = "R2 ignore";
    {a_hi, a_lo} = 32'hC001_D00D; {b_hi, b_lo} = 32'h0BAD_F00D; imode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    {a_hi, a_lo} = 32'h1111_1111; {b_hi, b_lo} = 32'h2222_2222; imode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    // R11: start held high, accepted again in the done cycle
    cur_tag = "R11 back-to-back";
    {a_hi, a_lo} = 32'hFEDC_BA98; {b_hi, b_lo} = 32'h8765_4321; imode = 1'b0;
    start = 1'b1;
    repeat (22) @(negedge clk);
    chk(phase == 11 && done, "R11 reaccept timing", 64'(phase), 64'd11);
    start = 1'b0;
    repeat (14) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule